// File: doc/BRIEF.md
# Adaptive Thread-Block Occupancy Governor

This block sits beside one shader core and decides how many thread blocks the core may keep running at once. Each cycle it observes two conditions the core reports. The first is an issue-starvation flag: the pipeline could accept work but has nothing to issue. The second is a memory-bound flag: every warp is blocked on outstanding loads. Over a configurable sampling window it counts the cycles in which each flag is high. At the end of the window it moves the occupancy limit up by one, down by one, or leaves it unchanged, and it pulses a strobe.

A block dispatcher admits a new thread block only while the resident count is below the limit. The warp arbiter deprioritises the youngest resident blocks whenever residency exceeds the limit. The governor reports how many such blocks are held back. A raise therefore releases a held-back block before it makes room for a fresh one, and a lowering holds back the youngest block. Blocks are never evicted.

Configuration (window length, three thresholds, hardware block ceiling) is captured only while `run` is low. During that time the limit is preset to half the ceiling.

Top module: `occupancy_governor`

## Requirements
- R1: While `run` is low, every configuration input is captured each cycle, and `blk_limit` is preset to max(1, floor(C/2)), where C is `cfg_max_blk`, read as 1 when it is 0. Both counters and the window position restart.
- R2: Two counters accumulate, within a window, the number of cycles with `core_idle` high and with `all_mem_wait` high. Each counter saturates at 2047 (all ones, 11 bits) rather than wrapping.
- R3: A window lasts W cycles of `run` high, where W is the captured `cfg_window`, read as 2 when below 2. The cycle after the W-th cycle shows `decide_stb` high for exactly one cycle and the new limit. The count of a window includes its last cycle, and the next window starts from zero.
- R4: When the idle count is at or above the idle threshold, the limit rises by one if it is below C.
- R5: Otherwise, when the memory-wait count is below the low threshold, the limit rises by one if it is below C.
- R6: Otherwise, when the memory-wait count is at or above the high threshold, the limit falls by one if it is above 1.
- R7: In every remaining case, and whenever a step would leave the range 1..C, the limit is unchanged.
- R8: While running, `blk_limit` changes only together with `decide_stb`, by at most one, and stays within 1..C.
- R9: `blk_paused` equals `resident_blks - blk_limit` when that is positive, otherwise 0, combinationally.
- R10: Changes on the configuration inputs while `run` is high have no effect on decisions.
- R11: During reset `blk_limit` is 1 and `decide_stb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High: governor operating; low: configuration capture and preset |
| cfg_window | input | 12 | Sampling window length in cycles |
| cfg_idle_thr | input | 11 | Idle-count threshold |
| cfg_mem_lo | input | 11 | Memory-wait low threshold |
| cfg_mem_hi | input | 11 | Memory-wait high threshold |
| cfg_max_blk | input | 4 | Hardware ceiling C on concurrent blocks |
| core_idle | input | 1 | Pipeline free but nothing issuable this cycle |
| all_mem_wait | input | 1 | Every warp waiting on memory this cycle |
| resident_blks | input | 4 | Blocks currently resident on the core |
| blk_limit | output | 4 | Current occupancy limit |
| blk_paused | output | 4 | Number of youngest resident blocks to hold back |
| decide_stb | output | 1 | One-cycle pulse marking a window decision |

## Verification
Counter saturation is the hardest behaviour to reach from the ports. It takes a full 2048-cycle window with a flag held high, and with an 11-bit wrap the count would silently read zero. The stimulus sets the thresholds to 2047 and the memory low threshold to 0. With those settings, a saturated count produces a move while a wrapped count produces a hold, so each 2048-cycle window gives a visible result. The decision tree itself is swept on short windows for every ceiling from 1 to 8 and every idle and memory-wait count around the thresholds. The configuration inputs are driven with misleading values during each run.

// File: rtl/ogov_pkg.sv
package ogov_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_RAISE = 2'd1,
    ACT_LOWER = 2'd2
  } act_e;
endpackage

// File: rtl/ogov_satcnt.sv
// Per-window event counter that sticks at all-ones.
module ogov_satcnt #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] sum
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt;

  // sum includes the current cycle's event
  always_comb sum = (inc && cnt != TOP) ? cnt + W'(1) : cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= sum;
  end

  AST_CNT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == TOP) |=> cnt == TOP); // R2
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr) |=> (cnt == $past(cnt) || cnt == $past(cnt) + W'(1))); // R2
endmodule

// File: rtl/ogov_policy.sv
// Window-end decision: idle first, then three memory-wait bands.
module ogov_policy
  import ogov_pkg::*;
#(
  parameter int CW = 11,
  parameter int BW = 4
) (
  input  logic [CW-1:0] idle_sum,
  input  logic [CW-1:0] mem_sum,
  input  logic [CW-1:0] thr_idle,
  input  logic [CW-1:0] thr_lo,
  input  logic [CW-1:0] thr_hi,
  input  logic [BW-1:0] lim,
  input  logic [BW-1:0] nmax,
  output act_e          act,
  output logic [BW-1:0] lim_nx
);
  act_e want;

  always_comb begin
    if (idle_sum >= thr_idle)  want = ACT_RAISE;
    else if (mem_sum < thr_lo) want = ACT_RAISE;
    else if (mem_sum >= thr_hi) want = ACT_LOWER;
    else                        want = ACT_HOLD;

    act = want;
    if (want == ACT_RAISE && lim >= nmax)     act = ACT_HOLD;
    if (want == ACT_LOWER && lim <= BW'(1))   act = ACT_HOLD;

    case (act)
      ACT_RAISE: lim_nx = lim + BW'(1);
      ACT_LOWER: lim_nx = lim - BW'(1);
      default:   lim_nx = lim;
    endcase
  end

  always_comb begin
    AST_NO_OVER_CEIL: assert (!(act == ACT_RAISE) || lim < nmax); // R4
    AST_NO_UNDER_ONE: assert (!(act == ACT_LOWER) || lim > BW'(1)); // R6
  end
endmodule

// File: rtl/occupancy_governor.sv
module occupancy_governor
  import ogov_pkg::*;
#(
  parameter int CNT_W    = 11,
  parameter int WIN_W    = 12,
  parameter int BLK_W    = 4,
  parameter int DEF_WIN  = 2048,
  parameter int DEF_IDLE = 16,
  parameter int DEF_LO   = 128,
  parameter int DEF_HI   = 384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [WIN_W-1:0] cfg_window,
  input  logic [CNT_W-1:0] cfg_idle_thr,
  input  logic [CNT_W-1:0] cfg_mem_lo,
  input  logic [CNT_W-1:0] cfg_mem_hi,
  input  logic [BLK_W-1:0] cfg_max_blk,
  input  logic             core_idle,
  input  logic             all_mem_wait,
  input  logic [BLK_W-1:0] resident_blks,
  output logic [BLK_W-1:0] blk_limit,
  output logic [BLK_W-1:0] blk_paused,
  output logic             decide_stb
);
  localparam logic [WIN_W-1:0] MIN_WIN = WIN_W'(2);
  localparam logic [BLK_W-1:0] ONE_BLK = BLK_W'(1);

  logic [WIN_W-1:0] win_q, wcnt;
  logic [CNT_W-1:0] thr_idle_q, thr_lo_q, thr_hi_q;
  logic [BLK_W-1:0] nmax_q, lim_q, lim_nx;
  logic             stb_q, active_q, wlast, clr;
  logic [CNT_W-1:0] idle_sum, mem_sum;
  logic [BLK_W-1:0] nmax_ld, half_ld, init_ld;
  logic [WIN_W-1:0] win_ld;
  act_e             act;

  // values captured while stopped
  always_comb begin
    nmax_ld = (cfg_max_blk == '0) ? ONE_BLK : cfg_max_blk;
    half_ld = nmax_ld >> 1;
    init_ld = (half_ld == '0) ? ONE_BLK : half_ld;
    win_ld  = (cfg_window < MIN_WIN) ? MIN_WIN : cfg_window;
  end

  assign wlast = run && (wcnt == win_q - WIN_W'(1));
  assign clr   = !run || wlast;

  ogov_satcnt #(.W(CNT_W)) u_idle_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(run && core_idle), .sum(idle_sum)
  );
  ogov_satcnt #(.W(CNT_W)) u_mem_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(run && all_mem_wait), .sum(mem_sum)
  );

  ogov_policy #(.CW(CNT_W), .BW(BLK_W)) u_policy (
    .idle_sum(idle_sum), .mem_sum(mem_sum),
    .thr_idle(thr_idle_q), .thr_lo(thr_lo_q), .thr_hi(thr_hi_q),
    .lim(lim_q), .nmax(nmax_q), .act(act), .lim_nx(lim_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q      <= WIN_W'(DEF_WIN);
      thr_idle_q <= CNT_W'(DEF_IDLE);
      thr_lo_q   <= CNT_W'(DEF_LO);
      thr_hi_q   <= CNT_W'(DEF_HI);
      nmax_q     <= ONE_BLK;
      lim_q      <= ONE_BLK;
      wcnt       <= '0;
      stb_q      <= 1'b0;
      active_q   <= 1'b0;
    end else if (!run) begin
      win_q      <= win_ld;
      thr_idle_q <= cfg_idle_thr;
      thr_lo_q   <= cfg_mem_lo;
      thr_hi_q   <= cfg_mem_hi;
      nmax_q     <= nmax_ld;
      lim_q      <= init_ld;
      wcnt       <= '0;
      stb_q      <= 1'b0;
      active_q   <= 1'b0;
    end else begin
      active_q <= 1'b1;
      stb_q    <= wlast;
      wcnt     <= wlast ? '0 : wcnt + WIN_W'(1);
      if (wlast) lim_q <= lim_nx;
    end
  end

  assign blk_limit  = lim_q;
  assign decide_stb = stb_q;
  assign blk_paused = (resident_blks > lim_q) ? resident_blks - lim_q : '0;

  AST_LIMIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (blk_limit >= ONE_BLK && blk_limit <= nmax_q)); // R8
  AST_LIMIT_ONLY_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && blk_limit != $past(blk_limit)) |-> decide_stb); // R8
  AST_LIMIT_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (blk_limit == $past(blk_limit) ||
                  blk_limit == $past(blk_limit) + ONE_BLK ||
                  $past(blk_limit) == blk_limit + ONE_BLK)); // R8
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    decide_stb |=> !decide_stb); // R3
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> ($stable(thr_idle_q) && $stable(nmax_q) && $stable(win_q))); // R10
endmodule

// File: tb/tb_occupancy_governor.sv
module tb_occupancy_governor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic [11:0] cfg_window = 12'd8;
  logic [10:0] cfg_idle_thr = '0, cfg_mem_lo = '0, cfg_mem_hi = '0;
  logic [3:0]  cfg_max_blk = 4'd4;
  logic        core_idle = 1'b0, all_mem_wait = 1'b0;
  logic [3:0]  resident_blks = '0;
  logic [3:0]  blk_limit, blk_paused;
  logic        decide_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_lim;
  int cfg_n, cfg_ti, cfg_lo, cfg_hi;

  always #2 clk = ~clk;

  occupancy_governor dut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_window(cfg_window),
    .cfg_idle_thr(cfg_idle_thr), .cfg_mem_lo(cfg_mem_lo), .cfg_mem_hi(cfg_mem_hi),
    .cfg_max_blk(cfg_max_blk), .core_idle(core_idle), .all_mem_wait(all_mem_wait),
    .resident_blks(resident_blks), .blk_limit(blk_limit), .blk_paused(blk_paused),
    .decide_stb(decide_stb)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start(input int n, input int w, input int ti, input int lo, input int hi);
    @(negedge clk);
    run = 1'b0;
    cfg_max_blk = 4'(n); cfg_window = 12'(w);
    cfg_idle_thr = 11'(ti); cfg_mem_lo = 11'(lo); cfg_mem_hi = 11'(hi);
    cfg_n = (n == 0) ? 1 : n;
    cfg_ti = ti; cfg_lo = lo; cfg_hi = hi;
    @(negedge clk);
    @(negedge clk);
    exp_lim = (cfg_n / 2 < 1) ? 1 : cfg_n / 2;
    chk("R1 preset limit", int'(blk_limit), exp_lim);
    chk("R1 no strobe while stopped", int'(decide_stb), 0);
    run = 1'b1;
    // R10: misleading values while running
    cfg_max_blk = 4'd15; cfg_window = 12'd3;
    cfg_idle_thr = 11'd0; cfg_mem_lo = 11'd0; cfg_mem_hi = 11'd0;
  endtask

  // expected limit after a window with given counts
  function automatic int model(input int lim, input int ic, input int mc, output string tag);
    int si, sm;
    si = (ic > 2047) ? 2047 : ic;
    sm = (mc > 2047) ? 2047 : mc;
    if (si >= cfg_ti) begin
      tag = "R4 idle raise";
      return (lim < cfg_n) ? lim + 1 : lim;
    end else if (sm < cfg_lo) begin
      tag = "R5 low-mem raise";
      return (lim < cfg_n) ? lim + 1 : lim;
    end else if (sm >= cfg_hi) begin
      tag = "R6 high-mem lower";
      return (lim > 1) ? lim - 1 : lim;
    end
    tag = "R7 hold";
    return lim;
  endfunction

  task automatic window(input int w, input int ic, input int mc, input int res);
    string tag;
    for (int k = 0; k < w; k++) begin
      core_idle = (k < ic);
      all_mem_wait = (k < mc);
      if (k == 1) chk("R3 no strobe mid-window", int'(decide_stb), 0);
      @(negedge clk);
    end
    core_idle = 1'b0; all_mem_wait = 1'b0;
    exp_lim = model(exp_lim, ic, mc, tag);
    chk(tag, int'(blk_limit), exp_lim);
    chk("R3 strobe after window", int'(decide_stb), 1);
    resident_blks = 4'(res);
    #1;
    chk("R9 paused count", int'(blk_paused), (res > exp_lim) ? res - exp_lim : 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset limit", int'(blk_limit), 1);
    chk("R11 reset strobe", int'(decide_stb), 0);
    rst_n = 1'b1;

    // decision tree sweep, R4..R8 and R10
    for (int n = 1; n <= 8; n++) begin
      start(n, 8, 3, 2, 5);
      for (int ic = 0; ic <= 3; ic++) begin
        if (ic == 1) continue;
        for (int mc = 0; mc <= 8; mc++)
          window(8, ic, mc, (ic * 9 + mc) % (n + 1));
      end
    end

    // R1: zero ceiling reads as one; R3: window below 2 reads as 2
    start(0, 1, 3, 2, 5);
    window(2, 0, 0, 0);
    window(2, 2, 2, 1);

    // R2: saturation over full 2048-cycle windows
    start(4, 2048, 2047, 0, 2047);
    window(2048, 2048, 0, 4);
    start(4, 2048, 2047, 0, 2047);
    window(2048, 0, 2048, 4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule